// File: doc/BRIEF.md
# Completion Data Byte-Enable Generator

This block sits on a read-completion stream that carries one dword per beat: a fixed number of header dwords come first, then the payload dwords, and the last beat of each completion is flagged. For every beat it attaches a 4-bit byte-enable mask and a 4-bit parity vector. These sideband signals are registered and stay aligned with the data beat they describe. Header beats get an empty mask. Payload beats get masks worked out from the completion's starting byte offset (the two low bits of its lower address), its remaining byte count and its payload length in dwords.

A completion can be partial: its byte count plus the start offset is more than its payload holds. In that case the final payload dword is fully enabled. For the completion that closes a request, only the bytes up to the end address are enabled. A one-dword payload gets the intersection of the first and last masks. The completion metadata is sampled on each completion's first beat. The slot state clears on every flagged last beat, so completions can follow one another with no gap.

Top module: `cpl_be_gen`

## Requirements
- R1: The first payload dword of a completion with two or more payload dwords has enable 4'hF shifted left by the offset (lower address bits [1:0]), keeping only the low 4 bits.
- R2: When byte count plus offset is no more than 4 times the payload length, the last payload dword (of two or more) enables bytes 0..n-1, where n = (offset + byte count) mod 4, and enables all four bytes when n is 0.
- R3: When byte count plus offset is more than 4 times the payload length, the last payload dword of the completion has enable 4'hF.
- R4: A payload of exactly one dword has enable equal to the bitwise AND of the R1 mask and the R2/R3 mask.
- R5: Every payload dword strictly between the first and the last has enable 4'hF.
- R6: The HDR_DW (default 3) header beats at the start of each completion have enable 4'b0000.
- R7: Parity bit i is 1 exactly when byte i (data bits 8i+7..8i) has an even number of ones, so each byte together with its parity bit has odd parity.
- R8: A completion with zero payload dwords consists only of its header beats, all with enable 0, and leaves the following completion's enables correct.
- R9: The output beat is registered and is held stable (valid, data, last, enable, parity) while out_valid_o is high and out_ready_i is low.
- R10: in_ready_o is high whenever out_ready_i is high, so back-to-back completions pass one beat per cycle with no idle cycle.
- R11: While rst_ni is low and after its release, out_valid_o is low until a beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high together with valid |
| in_data_i | input | 32 | Input dword |
| in_last_i | input | 1 | Last beat of the completion |
| lo_addr_i | input | ADDR_W | Completion lower address; only bits [1:0] are used; sampled on the first beat |
| byte_cnt_i | input | BC_W | Remaining byte count; sampled on the first beat |
| len_dw_i | input | LEN_W | Payload length in dwords; sampled on the first beat |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 32 | Output dword |
| out_last_o | output | 1 | Last beat of the completion |
| out_be_o | output | 4 | Byte-enable mask for this dword slot |
| out_par_o | output | 4 | Odd-parity bit for each byte |

## Verification
If the slot counter holds a wrong value, the error shows up on the very next output beat. A header slot then carries a nonzero mask, or a payload dword gets a header-style zero or middle-style 4'hF mask. The completion after a miscounted last beat then comes out with every mask shifted by one slot. Errors in the metadata latch or in the partial-completion compare appear only on the first or last payload beat of that same completion, one cycle after it is accepted. The sweep therefore covers every offset, byte counts that end at each byte lane, and both the partial and the final case for each.

// File: rtl/cpl_be_pkg.sv
package cpl_be_pkg;
  localparam int unsigned DW_BITS = 32;
  localparam int unsigned BE_W    = DW_BITS / 8;

  typedef enum logic [2:0] {
    BK_HDR,
    BK_FIRST,
    BK_MID,
    BK_LAST,
    BK_ONLY
  } beat_kind_e;
endpackage

// File: rtl/cpl_slot_track.sv
module cpl_slot_track
  import cpl_be_pkg::*;
#(
  parameter int unsigned HDR_DW = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       last_i,
  output beat_kind_e kind_o,
  output logic       first_beat_o
);
  localparam int unsigned CNT_W = $clog2(HDR_DW + 2) + 1;
  localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR_DW);

  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else if (adv_i) begin
      if (last_i)              slot_q <= '0;
      else if (slot_q <= HDR_C) slot_q <= slot_q + 1'b1; // saturate past first payload
    end
  end

  always_comb begin
    if (slot_q < HDR_C)       kind_o = BK_HDR;
    else if (slot_q == HDR_C) kind_o = last_i ? BK_ONLY : BK_FIRST;
    else                      kind_o = last_i ? BK_LAST : BK_MID;
  end

  assign first_beat_o = (slot_q == '0);
endmodule

// File: rtl/cpl_be_calc.sv
module cpl_be_calc
  import cpl_be_pkg::*;
#(
  parameter int unsigned BC_W  = 13,
  parameter int unsigned LEN_W = 11
) (
  input  logic [1:0]       off_i,
  input  logic [BC_W-1:0]  bc_i,
  input  logic [LEN_W-1:0] len_i,
  input  beat_kind_e       kind_i,
  output logic [BE_W-1:0]  be_o
);
  localparam int unsigned S_W = ((BC_W > LEN_W + 2) ? BC_W : LEN_W + 2) + 1;

  logic [S_W-1:0]  span, cap;
  logic            partial;
  logic [1:0]      tail_n;
  logic [BE_W-1:0] first_be, last_be, tail_be;

  assign first_be = 4'hF << off_i;
  assign span     = S_W'(bc_i) + S_W'(off_i);
  assign cap      = S_W'({len_i, 2'b00});
  assign partial  = span > cap;
  assign tail_n   = bc_i[1:0] + off_i;
  assign tail_be  = (tail_n == 2'd0) ? 4'hF : (4'hF >> (3'd4 - {1'b0, tail_n}));
  assign last_be  = partial ? 4'hF : tail_be;

  always_comb begin
    unique case (kind_i)
      BK_HDR:   be_o = '0;
      BK_FIRST: be_o = first_be;
      BK_MID:   be_o = 4'hF;
      BK_LAST:  be_o = last_be;
      BK_ONLY:  be_o = first_be & last_be;
      default:  be_o = '0;
    endcase
  end
endmodule

// File: rtl/cpl_par_gen.sv
module cpl_par_gen
  import cpl_be_pkg::*;
(
  input  logic [DW_BITS-1:0] data_i,
  output logic [BE_W-1:0]    par_o
);
  for (genvar i = 0; i < BE_W; i++) begin : g_byte
    assign par_o[i] = ~(^data_i[8*i +: 8]);
  end
endmodule

// File: rtl/cpl_be_gen.sv
module cpl_be_gen
  import cpl_be_pkg::*;
#(
  parameter int unsigned HDR_DW = 3,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned BC_W   = 13,
  parameter int unsigned LEN_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [31:0]       in_data_i,
  input  logic              in_last_i,
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [BC_W-1:0]   byte_cnt_i,
  input  logic [LEN_W-1:0]  len_dw_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [31:0]       out_data_o,
  output logic              out_last_o,
  output logic [3:0]        out_be_o,
  output logic [3:0]        out_par_o
);
  logic             accept, first_beat;
  beat_kind_e       kind;
  logic [1:0]       off_q, off_s;
  logic [BC_W-1:0]  bc_q, bc_s;
  logic [LEN_W-1:0] len_q, len_s;
  logic [BE_W-1:0]  be_d, par_d;

  logic             vld_q, last_q;
  logic [31:0]      data_q;
  logic [BE_W-1:0]  be_q, par_q;

  assign in_ready_o = !vld_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  cpl_slot_track #(.HDR_DW(HDR_DW)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (accept),
    .last_i      (in_last_i),
    .kind_o      (kind),
    .first_beat_o(first_beat)
  );

  // metadata is live on the first beat, latched for the rest of the completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      bc_q  <= '0;
      len_q <= '0;
    end else if (accept && first_beat) begin
      off_q <= lo_addr_i[1:0];
      bc_q  <= byte_cnt_i;
      len_q <= len_dw_i;
    end
  end

  assign off_s = first_beat ? lo_addr_i[1:0] : off_q;
  assign bc_s  = first_beat ? byte_cnt_i     : bc_q;
  assign len_s = first_beat ? len_dw_i       : len_q;

  cpl_be_calc #(.BC_W(BC_W), .LEN_W(LEN_W)) u_calc (
    .off_i (off_s),
    .bc_i  (bc_s),
    .len_i (len_s),
    .kind_i(kind),
    .be_o  (be_d)
  );

  cpl_par_gen u_par (
    .data_i(in_data_i),
    .par_o (par_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
      be_q   <= '0;
      par_q  <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        last_q <= in_last_i;
        data_q <= in_data_i;
        be_q   <= be_d;
        par_q  <= par_d;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_last_o  = last_q;
  assign out_data_o  = data_q;
  assign out_be_o    = be_q;
  assign out_par_o   = par_q;
endmodule

// File: rtl/cpl_be_gen_chk.sv
module cpl_be_gen_chk #(
  parameter int unsigned HDR_DW = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o,
  input logic        out_last_o,
  input logic [3:0]  out_be_o,
  input logic [3:0]  out_par_o
);
  localparam int unsigned CNT_W = $clog2(HDR_DW + 2) + 1;
  localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR_DW);

  logic [CNT_W-1:0] ocnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ocnt_q <= '0;
    else if (out_valid_o && out_ready_i) begin
      if (out_last_o)           ocnt_q <= '0;
      else if (ocnt_q <= HDR_C) ocnt_q <= ocnt_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_IDLE: assert (!out_valid_o); // R11
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_be_o)
      && $stable(out_par_o) && $stable(out_last_o)); // R9

  AST_HDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ocnt_q < HDR_C |-> out_be_o == 4'h0); // R6

  AST_MID_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ocnt_q > HDR_C && !out_last_o |-> out_be_o == 4'hF); // R5

  AST_PAR_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($countones({out_par_o[0], out_data_o[7:0]})   % 2 == 1)
                 && ($countones({out_par_o[1], out_data_o[15:8]})  % 2 == 1)
                 && ($countones({out_par_o[2], out_data_o[23:16]}) % 2 == 1)
                 && ($countones({out_par_o[3], out_data_o[31:24]}) % 2 == 1)); // R7

  AST_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R10
endmodule

bind cpl_be_gen cpl_be_gen_chk #(.HDR_DW(HDR_DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .out_last_o (out_last_o),
  .out_be_o   (out_be_o),
  .out_par_o  (out_par_o)
);

// File: tb/cpl_be_gen_test.sv
module cpl_be_gen_test;
  localparam int HDR = 3;
  localparam int MAXB = 2048;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic [6:0]  lo_addr_i = '0;
  logic [12:0] byte_cnt_i = '0;
  logic [10:0] len_dw_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic        out_last_o;
  logic [3:0]  out_be_o;
  logic [3:0]  out_par_o;

  always #5 clk_i = ~clk_i;

  cpl_be_gen uut (.*);

  logic [31:0] b_data [MAXB];
  logic        b_last [MAXB];
  logic [3:0]  b_be   [MAXB];
  logic [6:0]  b_addr [MAXB];
  logic [12:0] b_bc   [MAXB];
  logic [10:0] b_len  [MAXB];
  string       b_tag  [MAXB];
  int nb = 0;
  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected enable from byte positions: dword k covers bytes 4k..4k+3
  task automatic add_pkt(input int off, input int bc, input int len);
    bit partial = (bc + off) > len * 4;
    for (int s = 0; s < HDR + len; s++) begin
      logic [3:0] be = '0;
      string tag;
      if (s >= HDR) begin
        int k = s - HDR;
        for (int j = 0; j < 4; j++) begin
          int g = 4 * k + j;
          be[j] = (g >= off) && (partial || g < off + bc);
        end
      end
      if (s < HDR)               tag = (len == 0) ? "R8" : "R6";
      else if (len == 1)         tag = "R4";
      else if (s == HDR)         tag = "R1";
      else if (s == HDR + len - 1) tag = partial ? "R3" : "R2";
      else                       tag = "R5";
      b_data[nb] = (nb * 32'h9E3779B1) ^ (32'h01010101 * s) ^ {nb[7:0], 24'h5A3C00};
      b_last[nb] = (s == HDR + len - 1);
      b_be[nb]   = be;
      b_addr[nb] = 7'(off + 4 * (bc % 8));
      b_bc[nb]   = 13'(bc);
      b_len[nb]  = 11'(len);
      b_tag[nb]  = tag;
      nb++;
    end
  endtask

  initial begin
    int ip = 0, op = 0, cyc = 0;
    bit stall_prev = 0;
    logic [31:0] sd; logic [3:0] sb, sp; logic sl;

    // sweep offsets and byte counts, final and partial completions
    for (int off = 0; off < 4; off++) begin
      for (int bc = 1; bc <= 12; bc++) begin
        int fl = (off + bc + 3) / 4;
        add_pkt(off, bc, fl);
        if (fl > 1) add_pkt(off, bc, fl - 1);
        if (bc % 5 == 0) add_pkt(off, bc, 0);  // R8 zero-length in between
      end
    end
    add_pkt(0, 40, 0);
    add_pkt(1, 30, 8);

    // R11 reset state
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R11", "valid in reset", {31'b0, out_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R11", "valid after reset", {31'b0, out_valid_o}, 32'h0);

    while (op < nb) begin
      @(negedge clk_i);
      cyc++;
      if (cyc > 20000) begin
        bad++; total++;
        $display("FAIL watchdog op=%0d", op);
        break;
      end
      out_ready_i = (cyc > nb) || ((cyc % 4) != 2 && (cyc % 7) != 5);
      if (ip < nb) begin
        in_valid_i = 1'b1;
        in_data_i  = b_data[ip];
        in_last_i  = b_last[ip];
        lo_addr_i  = b_addr[ip];
        byte_cnt_i = b_bc[ip];
        len_dw_i   = b_len[ip];
      end else begin
        in_valid_i = 1'b0;
      end
      #1;
      if (stall_prev) begin // R9 hold under backpressure
        chk(out_valid_o && out_data_o == sd && out_be_o == sb && out_par_o == sp && out_last_o == sl,
            "R9", "stall hold", {out_data_o}, sd);
      end
      if (out_ready_i)      // R10
        chk(in_ready_o, "R10", "ready passthrough", {31'b0, in_ready_o}, 32'h1);
      if (out_valid_o && out_ready_i) begin
        logic [3:0] ep;
        for (int i = 0; i < 4; i++) ep[i] = ($countones(b_data[op][8*i +: 8]) % 2) == 0;
        chk(out_be_o == b_be[op], b_tag[op], "enable", {28'b0, out_be_o}, {28'b0, b_be[op]});
        chk(out_par_o == ep, "R7", "parity", {28'b0, out_par_o}, {28'b0, ep});
        chk(out_data_o == b_data[op] && out_last_o == b_last[op], "R9", "data/last",
            out_data_o, b_data[op]);
        op++;
      end
      stall_prev = out_valid_o && !out_ready_i;
      sd = out_data_o; sb = out_be_o; sp = out_par_o; sl = out_last_o;
      if (in_valid_i && in_ready_o) ip++;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule